// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block sits beside an 8-bit processor core and decides, at every instruction boundary, whether the core must begin an entry sequence before fetching its next opcode. There are three entry kinds: reset, non-maskable interrupt and maskable interrupt. When one is chosen, the block raises a one-hot start request for exactly one cycle and presents the 16-bit address of the vector the core must fetch. It also tells the core to set its interrupt-disable flag. The core's own sequencer then pushes registers and reads the vector bytes; that work is not part of this block.

The non-maskable line is edge-sensitive. The block latches a rising edge and keeps it pending until it is serviced. The maskable line is level-sensitive. It is gated by the core's interrupt-disable flag and passes through a pipeline that advances only on bus cycles, so a change on the line is seen one bus cycle late. A software break instruction asks the block for its vector when the core reaches its vector-select step. If a non-maskable request is pending at that moment, it takes over the break's vector and is consumed.

Top module: `intr_entry_seq`

## Requirements
- R1: After `rst_n` is released, a power-on request is pending, so the first boundary starts a reset sequence (`start_req` = 3'b100, `vec_addr` = 16'hFFFC). While `rst_n` is low, all outputs are zero.
- R2: When requests compete at a boundary, reset (power-on or latched `reset_req`) wins over the non-maskable request, and that request wins over the maskable one.
- R3: A non-maskable request is latched only on a low-to-high change of `nmi_in`. Holding the line high raises no further request.
- R4: Starting a non-maskable sequence clears the latched request, so a later boundary with no new edge starts nothing.
- R5: Each cycle with `bus_cycle` high samples `irq_in & ~iflag`. The pending maskable request takes the value that was sampled on the previous bus cycle. Cycles without `bus_cycle` leave both stages unchanged. A masked level never becomes pending.
- R6: `start_req` bit 2 means reset, bit 1 means non-maskable and bit 0 means maskable. The vectors are 16'hFFFC, 16'hFFFA and 16'hFFFE respectively.
- R7: A `brk_pick` without a boundary yields `vec_addr` 16'hFFFE with `start_req` zero. If a non-maskable request was already latched before that cycle, it yields 16'hFFFA instead and clears the request.
- R8: Results are registered. They appear in the cycle after the boundary and last one cycle, and at most one bit of `start_req` is ever set. A cycle with no boundary and no break pick gives `start_req` zero.
- R9: `set_iflag` pulses together with every entry start and every break vector. When it is low, `vec_addr` is zero.
- R10: `reset_req` is latched and serviced at a boundary. While it stays high, every boundary starts a further reset sequence.
- R11: When `boundary` and `brk_pick` coincide, the break pick is ignored. A non-maskable edge in the same cycle as a break pick is not consumed by that break; it stays pending for the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| reset_req | input | 1 | Reset request from the system, active high |
| nmi_in | input | 1 | Non-maskable interrupt line, active high, edge-sensitive |
| irq_in | input | 1 | Maskable interrupt line, active high, level-sensitive |
| iflag | input | 1 | Core's interrupt-disable flag |
| bus_cycle | input | 1 | High for one clock on each bus cycle of the core |
| boundary | input | 1 | High for one clock at each instruction boundary |
| brk_pick | input | 1 | Break instruction requests its vector |
| start_req | output | 3 | One-hot entry start: [2] reset, [1] non-maskable, [0] maskable |
| vec_addr | output | 16 | Vector address to fetch; zero when no vector is given |
| set_iflag | output | 1 | Core must set its interrupt-disable flag |

## Verification
A break pick and a non-maskable edge can land in the same cycle. A break pick can also coincide with a boundary. The bench provokes the first case by raising `nmi_in` in the very cycle of `brk_pick`, and expects the break to take 16'hFFFE while the next boundary starts a non-maskable sequence. It provokes the second case by driving `boundary` and `brk_pick` together, once with nothing pending (expected outputs all zero) and once with a latched edge (expected non-maskable start at 16'hFFFA). A scoreboard holds the expected result for each driven cycle and compares it in the following cycle.

// File: rtl/intr_seq_pkg.sv
// Package: shared constants for the interrupt entry sequencer.
// Assumes a 16-bit vector space and a three-way one-hot start request.
package intr_seq_pkg;
    localparam int VEC_W    = 16;
    localparam int START_W  = 3;
    // bit positions inside the one-hot start request
    localparam int ST_IRQ   = 0;
    localparam int ST_NMI   = 1;
    localparam int ST_RST   = 2;
    localparam logic [VEC_W-1:0] DEF_VEC_RST = 16'hFFFC;
    localparam logic [VEC_W-1:0] DEF_VEC_NMI = 16'hFFFA;
    localparam logic [VEC_W-1:0] DEF_VEC_IRQ = 16'hFFFE;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RST  = 2'd1,
        SRC_NMI  = 2'd2,
        SRC_IRQ  = 2'd3
    } src_e;
endpackage

// File: rtl/nmi_edge_latch.sv
// Module: nmi_edge_latch
// Latches a rising edge of the non-maskable line until it is cleared.
// Assumes nmi_line is already synchronous to clk. A new edge in the same
// cycle as a clear wins, so that request is not lost.
module nmi_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_line,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic rise;

    // purpose: detect a low-to-high change against last cycle's level
    always_comb rise = nmi_line & ~prev_q;

    // purpose: keep the previous level and the pending request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= nmi_line;
            pend   <= rise | (pend & ~clr);
        end
    end

    p_nmi_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_line && !prev_q) |=> pend);
    p_nmi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && nmi_line && prev_q) |=> !pend);
    p_nmi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !(nmi_line && !prev_q)) |=> !pend);
endmodule

// File: rtl/irq_sample_pipe.sv
// Module: irq_sample_pipe
// Samples the masked maskable-interrupt level on each bus cycle through
// STAGES registers. The last stage is the pending request. Assumes
// STAGES >= 1; with the default of 2 the pending bit trails the masked
// level by one bus cycle.
module irq_sample_pipe #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_cycle,
    input  logic irq_line,
    input  logic irq_mask,
    output logic pend
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] stg_q;

    // purpose: first stage captures the level with the disable flag applied
    always_ff @(posedge clk) begin
        if (!rst_n)
            stg_q[0] <= 1'b0;
        else if (bus_cycle)
            stg_q[0] <= irq_line & ~irq_mask;
    end

    genvar k;
    generate
        for (k = 1; k < STAGES; k++) begin : g_stage
            // purpose: advance the sample by one bus cycle
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stg_q[k] <= 1'b0;
                else if (bus_cycle)
                    stg_q[k] <= stg_q[k-1];
            end
        end
    endgenerate

    assign pend = stg_q[LAST];

    p_irq_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cycle && irq_mask) |=> !stg_q[0]);
    p_irq_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cycle |=> $stable(pend));
endmodule

// File: rtl/entry_arbiter.sv
// Module: entry_arbiter
// Holds the power-on and reset requests. At a boundary it picks the
// highest-priority pending source; otherwise it serves a break-vector
// request. Every result is registered and lasts one cycle.
// Assumes the boundary and brk_pick strobes are one clock wide.
module entry_arbiter
    import intr_seq_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_RST = DEF_VEC_RST,
    parameter logic [VEC_W-1:0] VEC_NMI = DEF_VEC_NMI,
    parameter logic [VEC_W-1:0] VEC_IRQ = DEF_VEC_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               boundary,
    input  logic               brk_pick,
    input  logic               nmi_pend,
    input  logic               irq_pend,
    output logic               nmi_clr,
    output logic [START_W-1:0] start_req,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               set_iflag
);
    logic             power_on_q;
    logic             rst_pend_q;
    logic             rst_any;
    src_e             sel;
    logic             brk_go;
    logic             go;
    logic [START_W-1:0] nxt_start;
    logic [VEC_W-1:0]   nxt_vec;

    // purpose: choose the entry source by fixed priority at a boundary
    always_comb begin
        rst_any = power_on_q | rst_pend_q;
        sel     = SRC_NONE;
        if (boundary) begin
            if (rst_any)       sel = SRC_RST;
            else if (nmi_pend) sel = SRC_NMI;
            else if (irq_pend) sel = SRC_IRQ;
        end
        brk_go = brk_pick & ~boundary;
    end

    // purpose: form the start request and vector for the chosen source
    always_comb begin
        nxt_start = '0;
        nxt_vec   = '0;
        case (sel)
            SRC_RST: begin
                nxt_start[ST_RST] = 1'b1;
                nxt_vec           = VEC_RST;
            end
            SRC_NMI: begin
                nxt_start[ST_NMI] = 1'b1;
                nxt_vec           = VEC_NMI;
            end
            SRC_IRQ: begin
                nxt_start[ST_IRQ] = 1'b1;
                nxt_vec           = VEC_IRQ;
            end
            default: begin
                if (brk_go)
                    nxt_vec = nmi_pend ? VEC_NMI : VEC_IRQ;
            end
        endcase
        go      = (sel != SRC_NONE) | brk_go;
        nmi_clr = (sel == SRC_NMI) | (brk_go & nmi_pend);
    end

    // purpose: track the power-on and reset requests, register the outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            power_on_q <= 1'b1;
            rst_pend_q <= 1'b0;
            start_req  <= '0;
            vec_addr   <= '0;
            set_iflag  <= 1'b0;
        end else begin
            power_on_q <= power_on_q & (sel != SRC_RST);
            rst_pend_q <= reset_req | (rst_pend_q & (sel != SRC_RST));
            start_req  <= nxt_start;
            vec_addr   <= nxt_vec;
            set_iflag  <= go;
        end
    end

    p_first_boundary_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && power_on_q) |=> (start_req[ST_RST] && vec_addr == VEC_RST));
    p_prio_nmi_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && !rst_any && nmi_pend) |=> (start_req[ST_NMI] && vec_addr == VEC_NMI));
    p_brk_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_pick && !boundary && nmi_pend) |=> (vec_addr == VEC_NMI && start_req == '0));
    p_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_req));
    p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!boundary && !brk_pick) |=> (start_req == '0 && !set_iflag));
    p_iflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (rst_any || nmi_pend || irq_pend)) |=> set_iflag);
endmodule

// File: rtl/intr_entry_seq.sv
// Module: intr_entry_seq (top)
// Connects the non-maskable edge latch, the maskable sampling pipeline and
// the priority arbiter. Assumes every input is synchronous to clk.
module intr_entry_seq
    import intr_seq_pkg::*;
#(
    parameter int               IRQ_STAGES = 2,
    parameter logic [VEC_W-1:0] VEC_RST    = DEF_VEC_RST,
    parameter logic [VEC_W-1:0] VEC_NMI    = DEF_VEC_NMI,
    parameter logic [VEC_W-1:0] VEC_IRQ    = DEF_VEC_IRQ
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reset_req,
    input  logic               nmi_in,
    input  logic               irq_in,
    input  logic               iflag,
    input  logic               bus_cycle,
    input  logic               boundary,
    input  logic               brk_pick,
    output logic [START_W-1:0] start_req,
    output logic [VEC_W-1:0]   vec_addr,
    output logic               set_iflag
);
    logic nmi_pend;
    logic nmi_clr;
    logic irq_pend;

    nmi_edge_latch u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_line (nmi_in),
        .clr      (nmi_clr),
        .pend     (nmi_pend)
    );

    irq_sample_pipe #(.STAGES(IRQ_STAGES)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_cycle (bus_cycle),
        .irq_line  (irq_in),
        .irq_mask  (iflag),
        .pend      (irq_pend)
    );

    entry_arbiter #(
        .VEC_RST (VEC_RST),
        .VEC_NMI (VEC_NMI),
        .VEC_IRQ (VEC_IRQ)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .boundary  (boundary),
        .brk_pick  (brk_pick),
        .nmi_pend  (nmi_pend),
        .irq_pend  (irq_pend),
        .nmi_clr   (nmi_clr),
        .start_req (start_req),
        .vec_addr  (vec_addr),
        .set_iflag (set_iflag)
    );

    p_vec_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !set_iflag |-> (vec_addr == '0 && start_req == '0));
endmodule

// File: tb/intr_entry_seq_test.sv
// Scoreboard bench: the driver queues the expected result of each driven
// cycle, and the monitor compares it after the following clock edge.
module intr_entry_seq_test;
    localparam int PERIOD = 10;

    // stimulus bit masks
    localparam logic [7:0] K_RSTN = 8'h80;
    localparam logic [7:0] K_HR   = 8'h40;
    localparam logic [7:0] K_NMI  = 8'h20;
    localparam logic [7:0] K_IRQ  = 8'h10;
    localparam logic [7:0] K_IFL  = 8'h08;
    localparam logic [7:0] K_BUS  = 8'h04;
    localparam logic [7:0] K_BND  = 8'h02;
    localparam logic [7:0] K_BRK  = 8'h01;

    localparam logic [2:0] S_RST = 3'b100;
    localparam logic [2:0] S_NMI = 3'b010;
    localparam logic [2:0] S_IRQ = 3'b001;

    typedef struct {
        logic [2:0]  st;
        logic [15:0] vec;
        logic        ifl;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n, reset_req, nmi_in, irq_in, iflag, bus_cycle, boundary, brk_pick;
    logic [2:0]  start_req;
    logic [15:0] vec_addr;
    logic        set_iflag;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    exp_t sb_q[$];

    intr_entry_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reset_req (reset_req),
        .nmi_in    (nmi_in),
        .irq_in    (irq_in),
        .iflag     (iflag),
        .bus_cycle (bus_cycle),
        .boundary  (boundary),
        .brk_pick  (brk_pick),
        .start_req (start_req),
        .vec_addr  (vec_addr),
        .set_iflag (set_iflag)
    );

    always #(PERIOD/2) clk = ~clk;

    // driver: apply one cycle of inputs and queue what must follow
    task automatic step(input logic [7:0] s, input logic [2:0] est,
                        input logic [15:0] evec, input string tag);
        exp_t e;
        @(negedge clk);
        rst_n     = s[7];
        reset_req = s[6];
        nmi_in    = s[5];
        irq_in    = s[4];
        iflag     = s[3];
        bus_cycle = s[2];
        boundary  = s[1];
        brk_pick  = s[0];
        e.st  = est;
        e.vec = evec;
        e.ifl = (evec != 16'h0000);
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // monitor: compare outputs a quarter period after each edge
    always @(posedge clk) begin
        #(PERIOD/4);
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            total++;
            if (start_req !== e.st || vec_addr !== e.vec || set_iflag !== e.ifl) begin
                bad++;
                $display("FAIL %s: got start=%b vec=%h iflag=%b, expected start=%b vec=%h iflag=%b",
                         e.tag, start_req, vec_addr, set_iflag, e.st, e.vec, e.ifl);
            end
        end
    end

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; reset_req = 0; nmi_in = 0; irq_in = 0;
        iflag = 0; bus_cycle = 0; boundary = 0; brk_pick = 0;
        // R1: reset state, then the power-on reset sequence
        step(8'h00, 3'b000, 16'h0000, "R1 reset state");
        step(8'h00, 3'b000, 16'h0000, "R1 reset state");
        step(K_RSTN, 3'b000, 16'h0000, "R8 idle");
        step(K_RSTN | K_BND, S_RST, 16'hFFFC, "R1 power-on reset");
        step(K_RSTN | K_BND, 3'b000, 16'h0000, "R10 power-on cleared");
        // R3 / R4: edge-latched non-maskable request
        step(K_RSTN | K_NMI, 3'b000, 16'h0000, "R3 edge latch");
        step(K_RSTN | K_NMI | K_BND, S_NMI, 16'hFFFA, "R6 nmi vector");
        step(K_RSTN | K_NMI | K_BND, 3'b000, 16'h0000, "R3 held line, R4 cleared");
        step(K_RSTN, 3'b000, 16'h0000, "R8 idle");
        // R5: maskable pipeline delay
        step(K_RSTN | K_IRQ | K_BND, 3'b000, 16'h0000, "R5 no bus cycle yet");
        step(K_RSTN | K_IRQ | K_BUS, 3'b000, 16'h0000, "R5 first sample");
        step(K_RSTN | K_IRQ | K_BND, 3'b000, 16'h0000, "R5 one-bus-cycle delay");
        step(K_RSTN | K_IRQ | K_BUS, 3'b000, 16'h0000, "R5 second sample");
        step(K_RSTN | K_BND, S_IRQ, 16'hFFFE, "R5 irq start");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R5 drain");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R5 drain");
        step(K_RSTN | K_BND, 3'b000, 16'h0000, "R5 level dropped");
        // R5: masking
        step(K_RSTN | K_IRQ | K_IFL | K_BUS, 3'b000, 16'h0000, "R5 masked");
        step(K_RSTN | K_IRQ | K_IFL | K_BUS, 3'b000, 16'h0000, "R5 masked");
        step(K_RSTN | K_IRQ | K_IFL | K_BND, 3'b000, 16'h0000, "R5 masked level ignored");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R8 idle");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R8 idle");
        // R2: all three sources pending together
        step(K_RSTN | K_IRQ | K_BUS, 3'b000, 16'h0000, "R2 setup");
        step(K_RSTN | K_IRQ | K_BUS | K_NMI, 3'b000, 16'h0000, "R2 setup");
        step(K_RSTN | K_HR | K_IRQ | K_NMI, 3'b000, 16'h0000, "R10 reset latched");
        step(K_RSTN | K_IRQ | K_NMI | K_BND, S_RST, 16'hFFFC, "R2 reset first");
        step(K_RSTN | K_IRQ | K_NMI | K_BND, S_NMI, 16'hFFFA, "R2 nmi second");
        step(K_RSTN | K_IRQ | K_BND, S_IRQ, 16'hFFFE, "R2 irq last");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R8 idle");
        step(K_RSTN | K_BUS, 3'b000, 16'h0000, "R8 idle");
        // R7: break vector and takeover by a pending non-maskable request
        step(K_RSTN | K_BRK, 3'b000, 16'hFFFE, "R7 plain break");
        step(K_RSTN | K_NMI, 3'b000, 16'h0000, "R7 edge latch");
        step(K_RSTN | K_NMI | K_BRK, 3'b000, 16'hFFFA, "R7 nmi takes break vector");
        step(K_RSTN | K_BND, 3'b000, 16'h0000, "R7 request consumed");
        // R11: coincident strobes
        step(K_RSTN | K_BND | K_BRK, 3'b000, 16'h0000, "R11 break ignored at boundary");
        step(K_RSTN | K_NMI, 3'b000, 16'h0000, "R11 edge latch");
        step(K_RSTN | K_NMI | K_BND | K_BRK, S_NMI, 16'hFFFA, "R11 boundary wins");
        step(K_RSTN, 3'b000, 16'h0000, "R8 idle");
        step(K_RSTN | K_NMI | K_BRK, 3'b000, 16'hFFFE, "R11 same-cycle edge not used by break");
        step(K_RSTN | K_NMI | K_BND, S_NMI, 16'hFFFA, "R11 edge kept for boundary");
        // R1: reset in mid-run restores power-on request
        step(8'h00, 3'b000, 16'h0000, "R1 reset clears outputs");
        step(K_RSTN, 3'b000, 16'h0000, "R8 idle");
        step(K_RSTN | K_BND, S_RST, 16'hFFFC, "R1 power-on again");
        // R10: held reset request
        step(K_RSTN | K_HR | K_BND, 3'b000, 16'h0000, "R10 request not yet latched");
        step(K_RSTN | K_HR | K_BND, S_RST, 16'hFFFC, "R10 reset start");
        step(K_RSTN | K_BND, S_RST, 16'hFFFC, "R10 held request repeats");
        step(K_RSTN | K_BND, 3'b000, 16'h0000, "R10 released");
        step(K_RSTN, 3'b000, 16'h0000, "R9 vector zero when idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule